// File: doc/BRIEF.md
# Panel Self-Refresh State Sequencer

This block is the source-side sequencer for panel self-refresh. It tracks which phase the link is in: off, armed but idle, entering with a static frame, fully self-refreshing, refreshing a single frame, or leaving self-refresh. Some steps happen only when software writes the control word. The others finish on their own after a short dwell. Software drives the block through a single write strobe and control word. The display pipeline supplies a per-frame strobe and a memory-update strobe.

Two entry styles are supported. In software-timer mode, the entry step is an explicit write. In automatic mode, a run of consecutive idle frames starts entry; the run length is programmable but never falls below a floor of six. Leaving self-refresh, whether requested by software or forced by a memory update, goes straight to the exit phase without passing through single-frame update. At that moment a one-cycle wake request is issued toward the auxiliary channel, so that the sink can be woken by a write of 01h to its register 600h. A small combinational helper computes the frame count to program before selective-update entry from the sink's resynchronisation latency.

Top module: `srf_sequencer`

## Requirements
- R1: After reset, `state_o` is 0, and `in_trans_o`, `wake_req_o` and `err_o` are all low.
- R2: The state code on `state_o` is 0 off, 1 idle, 2 entering, 3 live, 4 single-frame update, 5 exit. The control word has enable at bit 0, entry at bit 1, single-frame request at bit 2 and keep-transmitter at bit 3. The mode field is at bits 5:4, with 01 meaning software timer and 10 meaning automatic. In state 0, a write that sets enable and keep-transmitter, selects a valid mode and leaves entry and single-frame clear moves the state to 1 and no further. Repeating that write in state 1 changes nothing.
- R3: In state 1, a write with enable and entry set moves to state 2. The block then moves by itself to state 3 once it has spent DWELL cycles in state 2.
- R4: In state 3, a write with enable, entry and single-frame set moves to state 4. The next frame strobe returns the block to state 3.
- R5: In state 3, a write with enable set and entry clear moves straight to state 5 without visiting state 4. A memory-update strobe in state 3 or state 4 does the same. After DWELL cycles in state 5, the block returns by itself to state 1.
- R6: `wake_req_o` is high for exactly one cycle, and that cycle is the first cycle of state 5.
- R7: `in_trans_o` is high for exactly one cycle, the first cycle of state 3 after state 2 or the first cycle of state 1 after state 5. It is low at all other times.
- R8: A write with enable clear returns the block to state 0, but only from state 1 or state 3 and only in a cycle that follows a cycle with `in_trans_o` low. A disable written in state 2, 4 or 5 is held until the hardware step completes.
- R9: In automatic mode in state 1, entry to state 2 happens in the cycle after max(6, `idle_cfg`) consecutive frame strobes. A memory-update strobe restarts the count. In software-timer mode, frame strobes never cause entry.
- R10: `su_frames_o` equals `sink_lat`+1 when `sink_lat_ok` is high, and 1 otherwise.
- R11: A write that requests an illegal step is ignored and sets `err_o`, which stays high until reset. Illegal steps are: enable with entry from state 0, an invalid mode from state 0, any enabled write in state 2, 4 or 5, and an enabled write while a disable is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 8 | Control word |
| frame_stb | input | 1 | One pulse per frame |
| mem_upd | input | 1 | Frame-buffer activity strobe |
| idle_cfg | input | IDLE_W | Requested idle-frame count before automatic entry |
| sink_lat | input | LAT_W | Sink resynchronisation latency |
| sink_lat_ok | input | 1 | High when `sink_lat` was read successfully |
| state_o | output | 3 | Current state code |
| in_trans_o | output | 1 | Hardware-completed step marker |
| wake_req_o | output | 1 | Wake request pulse toward the auxiliary channel |
| err_o | output | 1 | Sticky illegal-request flag |
| su_frames_o | output | LAT_W+1 | Frames before selective-update entry |

## Verification
The hardest case to reach is a disable that lands on the same cycle as the one-cycle transition marker. The bench gets there by writing disable during the entry dwell. The pending disable then meets the arrival in state 3, while the marker is high. The bench expects one more cycle in state 3 before the block turns off. The automatic-entry count is also checked with a memory update in the middle of a run, so the floor of six frames has to be met twice.

// File: rtl/srf_pkg.sv
package srf_pkg;

    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_IDLE  = 3'd1,
        ST_ENTRY = 3'd2,
        ST_LIVE  = 3'd3,
        ST_SFU   = 3'd4,
        ST_EXIT  = 3'd5
    } srf_state_e;

    typedef enum logic [1:0] {
        MODE_NONE    = 2'd0,
        MODE_SWTIMER = 2'd1,
        MODE_AUTO    = 2'd2,
        MODE_RSVD    = 2'd3
    } srf_mode_e;

    // Control word, LSB first: enable, entry, single-frame, keep-tx, mode[1:0].
    typedef struct packed {
        logic [1:0] spare;
        srf_mode_e  mode;
        logic       keep_tx;
        logic       sfu;
        logic       entry;
        logic       en;
    } srf_ctl_t;

    localparam int CTL_W = $bits(srf_ctl_t);

    typedef enum logic [2:0] {
        REQ_NONE  = 3'd0,
        REQ_ON    = 3'd1,
        REQ_ENTER = 3'd2,
        REQ_SFU   = 3'd3,
        REQ_EXIT  = 3'd4,
        REQ_OFF   = 3'd5,
        REQ_BAD   = 3'd6
    } srf_req_e;

    function automatic logic srf_mode_ok(srf_mode_e m);
        return (m == MODE_SWTIMER) || (m == MODE_AUTO);
    endfunction

    function automatic logic srf_is_hw_step(srf_state_e st);
        return (st == ST_ENTRY) || (st == ST_EXIT);
    endfunction

    // Classify a control write against the current state.
    function automatic srf_req_e srf_decode(srf_state_e st, srf_ctl_t c, logic off_pend);
        srf_req_e r;
        r = REQ_NONE;
        if (!c.en) begin
            r = (st == ST_OFF) ? REQ_NONE : REQ_OFF;
        end else if (off_pend) begin
            r = REQ_BAD;
        end else begin
            unique case (st)
                ST_OFF:  r = (!c.entry && !c.sfu && c.keep_tx && srf_mode_ok(c.mode))
                             ? REQ_ON : REQ_BAD;
                ST_IDLE: r = c.sfu ? REQ_BAD : (c.entry ? REQ_ENTER : REQ_NONE);
                ST_LIVE: r = !c.entry ? REQ_EXIT : (c.sfu ? REQ_SFU : REQ_NONE);
                default: r = REQ_BAD;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/srf_req_decode.sv
module srf_req_decode
    import srf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr,
    input  logic [CTL_W-1:0]     wdata,
    input  srf_state_e           state,
    input  logic                 off_pend,
    output srf_req_e             req,
    output srf_mode_e            mode_q,
    output logic                 err_q
);
    srf_ctl_t ctl;

    always_comb begin
        ctl = srf_ctl_t'(wdata);
        req = wr ? srf_decode(state, ctl, off_pend) : REQ_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_NONE;
            err_q  <= 1'b0;
        end else begin
            if (req == REQ_ON)
                mode_q <= ctl.mode;
            if (req == REQ_BAD)
                err_q <= 1'b1;
        end
    end
endmodule

// File: rtl/srf_idle_count.sv
module srf_idle_count #(
    parameter int IDLE_W   = 5,
    parameter int IDLE_MIN = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm,
    input  logic              frame_stb,
    input  logic              mem_upd,
    input  logic [IDLE_W-1:0] idle_cfg,
    output logic              hit
);
    localparam logic [IDLE_W-1:0] FLOOR = IDLE_W'(IDLE_MIN);

    logic [IDLE_W-1:0] thr;
    logic [IDLE_W-1:0] cnt_q;

    always_comb begin
        thr = (idle_cfg < FLOOR) ? FLOOR : idle_cfg;
        hit = arm && (cnt_q >= thr);
    end

    always_ff @(posedge clk) begin
        if (rst || !arm || mem_upd)
            cnt_q <= '0;
        else if (frame_stb && (cnt_q < thr))
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/srf_dwell_timer.sv
module srf_dwell_timer #(
    parameter int DWELL = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic busy,
    output logic done
);
    localparam int CW = $clog2(DWELL + 1);
    localparam logic [CW-1:0] LAST = CW'(DWELL - 1);

    logic [CW-1:0] cnt_q;

    assign done = busy && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !busy || done)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/srf_state_fsm.sv
module srf_state_fsm
    import srf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  srf_req_e   req,
    input  logic       mem_upd,
    input  logic       frame_stb,
    input  logic       idle_hit,
    input  logic       dwell_done,
    output srf_state_e state_q,
    output logic       off_pend_q,
    output logic       in_trans_q,
    output logic       wake_q
);
    srf_state_e state_n;
    logic       in_trans_n;
    logic       wake_n;
    logic       off_now;
    logic       off_pend_n;

    always_comb begin
        state_n    = state_q;
        in_trans_n = 1'b0;
        wake_n     = 1'b0;
        off_now    = ((req == REQ_OFF) || off_pend_q) && !in_trans_q;
        unique case (state_q)
            ST_OFF: begin
                if (req == REQ_ON)
                    state_n = ST_IDLE;
            end
            ST_IDLE: begin
                if (off_now)
                    state_n = ST_OFF;
                else if ((req == REQ_ENTER) || idle_hit)
                    state_n = ST_ENTRY;
            end
            ST_ENTRY: begin
                if (dwell_done) begin
                    state_n    = ST_LIVE;
                    in_trans_n = 1'b1;
                end
            end
            ST_LIVE: begin
                if (off_now) begin
                    state_n = ST_OFF;
                end else if (mem_upd || (req == REQ_EXIT)) begin
                    state_n = ST_EXIT;
                    wake_n  = 1'b1;
                end else if (req == REQ_SFU) begin
                    state_n = ST_SFU;
                end
            end
            ST_SFU: begin
                if (mem_upd) begin
                    state_n = ST_EXIT;
                    wake_n  = 1'b1;
                end else if (frame_stb) begin
                    state_n = ST_LIVE;
                end
            end
            ST_EXIT: begin
                if (dwell_done) begin
                    state_n    = ST_IDLE;
                    in_trans_n = 1'b1;
                end
            end
            default: state_n = ST_OFF;
        endcase
        off_pend_n = (off_pend_q || (req == REQ_OFF)) && (state_n != ST_OFF);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_OFF;
            off_pend_q <= 1'b0;
            in_trans_q <= 1'b0;
            wake_q     <= 1'b0;
        end else begin
            state_q    <= state_n;
            off_pend_q <= off_pend_n;
            in_trans_q <= in_trans_n;
            wake_q     <= wake_n;
        end
    end
endmodule

// File: rtl/srf_sequencer.sv
module srf_sequencer
    import srf_pkg::*;
#(
    parameter int DWELL    = 3,
    parameter int IDLE_W   = 5,
    parameter int IDLE_MIN = 6,
    parameter int LAT_W    = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ctl_wr,
    input  logic [CTL_W-1:0]   ctl_wdata,
    input  logic               frame_stb,
    input  logic               mem_upd,
    input  logic [IDLE_W-1:0]  idle_cfg,
    input  logic [LAT_W-1:0]   sink_lat,
    input  logic               sink_lat_ok,
    output logic [2:0]         state_o,
    output logic               in_trans_o,
    output logic               wake_req_o,
    output logic               err_o,
    output logic [LAT_W:0]     su_frames_o
);
    srf_req_e   req;
    srf_mode_e  mode_q;
    srf_state_e state_q;
    logic       off_pend;
    logic       idle_hit;
    logic       dwell_done;
    logic       arm;

    assign arm = (state_q == ST_IDLE) && (mode_q == MODE_AUTO);

    srf_req_decode u_dec (
        .clk      (clk),
        .rst      (rst),
        .wr       (ctl_wr),
        .wdata    (ctl_wdata),
        .state    (state_q),
        .off_pend (off_pend),
        .req      (req),
        .mode_q   (mode_q),
        .err_q    (err_o)
    );

    srf_idle_count #(.IDLE_W(IDLE_W), .IDLE_MIN(IDLE_MIN)) u_idle (
        .clk       (clk),
        .rst       (rst),
        .arm       (arm),
        .frame_stb (frame_stb),
        .mem_upd   (mem_upd),
        .idle_cfg  (idle_cfg),
        .hit       (idle_hit)
    );

    srf_dwell_timer #(.DWELL(DWELL)) u_dwell (
        .clk  (clk),
        .rst  (rst),
        .busy (srf_is_hw_step(state_q)),
        .done (dwell_done)
    );

    srf_state_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .mem_upd    (mem_upd),
        .frame_stb  (frame_stb),
        .idle_hit   (idle_hit),
        .dwell_done (dwell_done),
        .state_q    (state_q),
        .off_pend_q (off_pend),
        .in_trans_q (in_trans_o),
        .wake_q     (wake_req_o)
    );

    assign state_o = state_q;

    // Frames before selective-update entry: latency + 1, latency 0 when unreadable.
    always_comb begin
        su_frames_o = (sink_lat_ok ? {1'b0, sink_lat} : '0) + 1'b1;
    end
endmodule

// File: rtl/srf_sequencer_chk.sv
module srf_sequencer_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] state_o,
    input logic       in_trans_o,
    input logic       wake_req_o,
    input logic       err_o
);
    a_r2_code_range: assert property (@(posedge clk) disable iff (rst)
        state_o <= 3'd5);

    a_r3_entry_advances: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd2) |=> (state_o == 3'd2) || (state_o == 3'd3));

    a_r5_exit_returns: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd5) |=> (state_o == 3'd5) || (state_o == 3'd1));

    a_r5_exit_origin: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd5 && $past(state_o) != 3'd5)
            |-> ($past(state_o) == 3'd3) || ($past(state_o) == 3'd4));

    a_r6_wake_on_exit: assert property (@(posedge clk) disable iff (rst)
        wake_req_o |-> (state_o == 3'd5) && ($past(state_o) != 3'd5));

    a_r6_wake_single: assert property (@(posedge clk) disable iff (rst)
        wake_req_o |=> !wake_req_o);

    a_r7_trans_single: assert property (@(posedge clk) disable iff (rst)
        in_trans_o |=> !in_trans_o);

    a_r7_trans_arrival: assert property (@(posedge clk) disable iff (rst)
        in_trans_o |-> ((state_o == 3'd3) && ($past(state_o) == 3'd2))
                    || ((state_o == 3'd1) && ($past(state_o) == 3'd5)));

    a_r8_off_when_quiet: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd0 && $past(state_o) != 3'd0) |-> !$past(in_trans_o));

    a_r11_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o);
endmodule

bind srf_sequencer srf_sequencer_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .state_o    (state_o),
    .in_trans_o (in_trans_o),
    .wake_req_o (wake_req_o),
    .err_o      (err_o)
);

// File: tb/srf_sequencer_bench.sv
`timescale 1ns/1ps
module srf_sequencer_bench;
    localparam int DWELL = 3;
    localparam int IDLE_W = 5;
    localparam int LAT_W = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ctl_wr = 1'b0;
    logic [7:0]        ctl_wdata = '0;
    logic              frame_stb = 1'b0;
    logic              mem_upd = 1'b0;
    logic [IDLE_W-1:0] idle_cfg = '0;
    logic [LAT_W-1:0]  sink_lat = '0;
    logic              sink_lat_ok = 1'b0;
    logic [2:0]        state_o;
    logic              in_trans_o;
    logic              wake_req_o;
    logic              err_o;
    logic [LAT_W:0]    su_frames_o;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    srf_sequencer #(.DWELL(DWELL), .IDLE_W(IDLE_W), .LAT_W(LAT_W)) u_srf_sequencer (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .frame_stb(frame_stb), .mem_upd(mem_upd), .idle_cfg(idle_cfg),
        .sink_lat(sink_lat), .sink_lat_ok(sink_lat_ok), .state_o(state_o),
        .in_trans_o(in_trans_o), .wake_req_o(wake_req_o), .err_o(err_o),
        .su_frames_o(su_frames_o)
    );

    // Control words: 0x19 enable/sw-timer, 0x1B + entry, 0x1F + single-frame,
    // 0x29 enable/automatic, 0x09 enable with no mode, 0x00 disable.
    // Vector: kind[17:16] (0 write,1 frame,2 mem,3 wait), data, wait, state, err.
    localparam int NV = 15;
    localparam logic [17:0] VEC [NV] = '{
        {2'd0, 8'h19, 4'd0, 3'd1, 1'b0},
        {2'd0, 8'h19, 4'd0, 3'd1, 1'b0},
        {2'd0, 8'h1B, 4'd0, 3'd2, 1'b0},
        {2'd3, 8'h00, 4'd2, 3'd2, 1'b0},
        {2'd3, 8'h00, 4'd1, 3'd3, 1'b0},
        {2'd0, 8'h1F, 4'd0, 3'd4, 1'b0},
        {2'd1, 8'h00, 4'd0, 3'd3, 1'b0},
        {2'd0, 8'h19, 4'd0, 3'd5, 1'b0},
        {2'd3, 8'h00, 4'd3, 3'd1, 1'b0},
        {2'd0, 8'h1B, 4'd0, 3'd2, 1'b0},
        {2'd3, 8'h00, 4'd3, 3'd3, 1'b0},
        {2'd2, 8'h00, 4'd0, 3'd5, 1'b0},
        {2'd3, 8'h00, 4'd3, 3'd1, 1'b0},
        {2'd0, 8'h00, 4'd1, 3'd0, 1'b0},
        {2'd0, 8'h1B, 4'd0, 3'd0, 1'b1}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; ctl_wr = 1'b0; ctl_wdata = '0; frame_stb = 1'b0; mem_upd = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d);
        ctl_wr = 1'b1; ctl_wdata = d;
        @(negedge clk);
        ctl_wr = 1'b0; ctl_wdata = '0;
    endtask

    task automatic frame();
        frame_stb = 1'b1;
        @(negedge clk);
        frame_stb = 1'b0;
    endtask

    task automatic memup();
        mem_upd = 1'b1;
        @(negedge clk);
        mem_upd = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        chk("R1 reset state", state_o, 0);
        chk("R1 reset in_trans", in_trans_o, 0);
        chk("R1 reset wake", wake_req_o, 0);
        chk("R1 reset err", err_o, 0);

        // Table walk: R2 R3 R4 R5 R8 R11 sequence in software-timer mode.
        for (int i = 0; i < NV; i++) begin
            logic [17:0] v;
            v = VEC[i];
            case (v[17:16])
                2'd0: wr(v[15:8]);
                2'd1: frame();
                2'd2: memup();
                default: ;
            endcase
            step(int'(v[7:4]));
            chk($sformatf("R2 R3 R4 R5 table step %0d state", i), state_o, int'(v[3:1]));
            chk($sformatf("R11 table step %0d err", i), err_o, int'(v[0]));
        end

        // R6 / R7 pulse timing.
        do_reset();
        wr(8'h19);
        wr(8'h1B);
        chk("R7 no marker on entering state 2", in_trans_o, 0);
        step(2);
        chk("R3 still entering before dwell", state_o, 2);
        step(1);
        chk("R3 live after dwell", state_o, 3);
        chk("R7 marker on arrival in 3", in_trans_o, 1);
        step(1);
        chk("R7 marker drops", in_trans_o, 0);
        wr(8'h19);
        chk("R5 exit state", state_o, 5);
        chk("R6 wake on exit", wake_req_o, 1);
        step(1);
        chk("R6 wake single cycle", wake_req_o, 0);
        step(2);
        chk("R5 back to idle", state_o, 1);
        chk("R7 marker on return to 1", in_trans_o, 1);
        step(1);
        chk("R7 marker drops after return", in_trans_o, 0);

        // R8 disable written during entry, meets the marker cycle.
        do_reset();
        wr(8'h19);
        wr(8'h1B);
        wr(8'h00);
        chk("R8 disable held in state 2", state_o, 2);
        step(1);
        chk("R8 still entering", state_o, 2);
        step(1);
        chk("R8 step completes to 3", state_o, 3);
        chk("R8 marker high at arrival", in_trans_o, 1);
        step(1);
        chk("R8 waits while marker was high", state_o, 3);
        step(1);
        chk("R8 off after marker low", state_o, 0);
        chk("R8 disable is legal", err_o, 0);

        // R9 automatic entry with floor of six and a restart.
        do_reset();
        idle_cfg = 5'd2;
        wr(8'h29);
        repeat (4) frame();
        memup();
        repeat (5) frame();
        step(1);
        chk("R9 five frames after restart stay idle", state_o, 1);
        frame();
        chk("R9 sixth frame, entry next cycle", state_o, 1);
        step(1);
        chk("R9 entry after six idle frames", state_o, 2);

        do_reset();
        idle_cfg = 5'd9;
        wr(8'h29);
        repeat (8) frame();
        step(1);
        chk("R9 eight of nine frames stay idle", state_o, 1);
        frame();
        step(1);
        chk("R9 entry after nine frames", state_o, 2);

        do_reset();
        idle_cfg = 5'd2;
        wr(8'h19);
        repeat (10) frame();
        step(1);
        chk("R9 software-timer mode ignores idle frames", state_o, 1);

        // R10 selective-update frame count.
        sink_lat = 4'd5; sink_lat_ok = 1'b1;
        #1 chk("R10 latency 5 gives 6", su_frames_o, 6);
        sink_lat = 4'd15;
        #1 chk("R10 latency 15 gives 16", su_frames_o, 16);
        sink_lat_ok = 1'b0;
        #1 chk("R10 unreadable latency gives 1", su_frames_o, 1);
        @(negedge clk);

        // R11 illegal writes.
        do_reset();
        wr(8'h09);
        chk("R11 enable without mode ignored", state_o, 0);
        chk("R11 enable without mode flags error", err_o, 1);
        wr(8'h19);
        chk("R11 legal write still works", state_o, 1);
        chk("R11 error stays set", err_o, 1);
        do_reset();
        wr(8'h19);
        wr(8'h1B);
        wr(8'h1F);
        chk("R11 write during entry ignored", state_o, 2);
        chk("R11 write during entry flags error", err_o, 1);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        finished = 1'b1;
        $finish;
    end

    initial begin
        #(4 * 50000);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule